// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the multiplexed external memory strobes for a small 8-bit controller core. The core's machine cycle is twelve oscillator clocks, and this block runs on the oscillator clock. Each machine cycle carries one bus request: idle, code fetch, data read or data write. The request is sampled in the last clock of the previous cycle, which the block marks with `cyc_last`.

A fetch cycle reads two code bytes, one at the request address and one at the following address. The two are decoded separately against the on-chip code range. When `int_code_en` is high, addresses up to the internal code limit (0x0FFF by default) are served on chip and produce no program-store strobe; above the limit, and at every address when `int_code_en` is low, the byte is fetched from outside. The address latch strobe pulses twice per machine cycle, except in a data cycle, where the second pulse is left out and both program-store strobes are left out as well.

In a data cycle the low address byte goes out on the shared low bus, and a read or write strobe follows. The high port carries either the upper address byte (16-bit data addressing) or the core's own port latch value (8-bit data addressing). A byte sampled from the shared bus is returned on `rdata`, with `rvalid` pulsed for one clock.

Top module: `xbus_seq`

## Requirements
- R1: While `rst_n` is low: `ale`=0; `psen_n`, `rd_n` and `wr_n` are 1; `p0_oe`=0; `rvalid`=0; `cyc_last`=1.
- R2: A machine cycle is 12 clocks, numbered 0 to 11. `cyc_last` is high in clock 11 only. The request inputs are sampled at the clock edge that ends clock 11. `req_kind` encodes 0 = idle, 1 = fetch, 2 = read, 3 = write. The first cycle after reset starts one clock after `rst_n` goes high.
- R3: In idle and fetch cycles, `ale` is high in clocks 0-1 and 6-7, which gives two pulses of 2 clocks each. In read and write cycles, `ale` is high in clocks 0-1 only.
- R4: In a fetch cycle, `psen_n` is low in clocks 3-5 for an external first byte and in clocks 9-11 for an external second byte. It is never low in idle, read or write cycles.
- R5: The first byte of a fetch uses the request address A, and the second uses A+1 modulo 2^16. Each byte is external when `int_code_en`=0 or when its own address is above 0x0FFF. An internal byte produces no `psen_n` pulse, no bus drive and no `rvalid`.
- R6: `p0_oe`=1 and `p0_out` carries the byte's low address in clocks 0-2 of an external first byte and in clocks 6-8 of an external second byte. The same holds in clocks 0-2 of every read or write cycle. `p0_oe` is 0 while `psen_n` or `rd_n` is low.
- R7: `rd_n` (read) or `wr_n` (write) is low in clocks 5-10, which is 6 clocks starting 3 clocks after `ale` falls.
- R8: In a write cycle, `p0_oe`=1 and `p0_out`=`req_wdata` in clocks 3-11, so the data is held one clock after `wr_n` rises.
- R9: `p2_out` is the high address byte during an external fetch byte, and during a data cycle with `req_wide`=1. At all other times it is `p2_hold`. This covers data cycles with `req_wide`=0, idle cycles and internal fetch bytes.
- R10: `p0_in` is sampled at the edge that ends the last low clock of `psen_n` (external fetch byte) or of `rd_n`. In the clock that follows, `rvalid`=1 and `rdata` holds the sampled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_kind | input | 2 | Request for the next cycle: 0 idle, 1 fetch, 2 read, 3 write |
| req_addr | input | 16 | Code or data address |
| req_wdata | input | 8 | Write data byte |
| req_wide | input | 1 | 1 = 16-bit data addressing, 0 = 8-bit |
| int_code_en | input | 1 | 1 = low code range served on chip |
| p2_hold | input | 8 | High port latch value |
| p0_in | input | 8 | Shared low bus input |
| cyc_last | output | 1 | Last clock of the machine cycle |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Shared low bus output value |
| p0_oe | output | 1 | Shared low bus drive enable |
| p2_out | output | 8 | High port output |
| rdata | output | 8 | Byte sampled from the bus |
| rvalid | output | 1 | `rdata` is new this clock |

## Verification
The width and ordering properties assume that the request inputs change only in the last clock of a cycle. They also assume that `p2_hold` is steady within a cycle. The bench drives every request on the falling edge of that last clock and holds it for the whole cycle. Its bus model latches the address when `ale` falls and answers on `p0_in` only while a read or program-store strobe is low. This keeps the capture property tied to the data the bench actually returned.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_IDLE  = 2'd0,
    XK_FETCH = 2'd1,
    XK_READ  = 2'd2,
    XK_WRITE = 2'd3
  } xkind_t;

  localparam int MC_CLKS = 12;
  localparam int PH_W    = $clog2(MC_CLKS);
  typedef logic [PH_W-1:0] ph_t;

  localparam ph_t PH_ZERO    = ph_t'(0);
  localparam ph_t PH_LAST    = ph_t'(MC_CLKS - 1);
  localparam ph_t HALF_CLKS  = ph_t'(MC_CLKS / 2);
  localparam ph_t ALE_CLKS   = ph_t'(2);
  localparam ph_t ADDR_SLOT  = ph_t'(ALE_CLKS + 1);
  localparam ph_t PSEN_START = ADDR_SLOT;
  localparam ph_t PSEN_CLKS  = ph_t'(HALF_CLKS - PSEN_START);
  localparam ph_t PSEN_END   = ph_t'(PSEN_START + PSEN_CLKS - 1);
  localparam ph_t STB_GAP    = ph_t'(3);
  localparam ph_t STB_START  = ph_t'(ALE_CLKS + STB_GAP);
  localparam ph_t STB_CLKS   = ph_t'(6);
  localparam ph_t STB_END    = ph_t'(STB_START + STB_CLKS - 1);

  function automatic logic ph_in(ph_t ph, ph_t start, ph_t len);
    return (ph >= start) && ((ph - start) < len);
  endfunction

  function automatic ph_t ph_fold(ph_t ph);
    return (ph >= HALF_CLKS) ? ph - HALF_CLKS : ph;
  endfunction
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output ph_t  ph,
  output ph_t  hph,
  output logic half,
  output logic last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_LAST;
    else if (last) ph <= PH_ZERO;
    else ph <= ph + ph_t'(1);
  end

  assign last = (ph == PH_LAST);
  assign half = (ph >= HALF_CLKS);
  assign hph  = ph_fold(ph);
endmodule

// File: rtl/xbus_code_dec.sv
module xbus_code_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic                    int_en,
  output logic [1:0][ADDR_W-1:0]  haddr,
  output logic [1:0]              ext
);
  for (genvar g = 0; g < 2; g++) begin : g_half
    assign haddr[g] = base + ADDR_W'(g);
    assign ext[g]   = !int_en || (haddr[g] > INT_LAST);
  end
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  xkind_t             kind,
  input  ph_t                ph,
  input  ph_t                hph,
  input  logic               half,
  input  logic               ext_now,
  input  logic [ADDR_W-1:0]  addr_now,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               wide,
  input  logic [HI_W-1:0]    p2_hold,
  output logic               ale,
  output logic               psen_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic [DATA_W-1:0]  p0_out,
  output logic               p0_oe,
  output logic [HI_W-1:0]    p2_out,
  output logic               cap
);
  logic is_fetch, is_rd, is_wr, is_data;
  logic fetch_ext, addr_slot, stb_win, wdrive, adrive;

  assign is_fetch  = (kind == XK_FETCH);
  assign is_rd     = (kind == XK_READ);
  assign is_wr     = (kind == XK_WRITE);
  assign is_data   = is_rd || is_wr;
  assign fetch_ext = is_fetch && ext_now;
  assign addr_slot = ph_in(hph, PH_ZERO, ADDR_SLOT);
  assign stb_win   = is_data && ph_in(ph, STB_START, STB_CLKS);

  assign ale    = ph_in(hph, PH_ZERO, ALE_CLKS) && !(half && is_data);
  assign psen_n = !(fetch_ext && ph_in(hph, PSEN_START, PSEN_CLKS));
  assign rd_n   = !(is_rd && stb_win);
  assign wr_n   = !(is_wr && stb_win);

  assign wdrive = is_wr && (ph >= ADDR_SLOT);
  assign adrive = addr_slot && (fetch_ext || (is_data && !half));
  assign p0_oe  = wdrive || adrive;
  assign p0_out = wdrive ? wdata : addr_now[DATA_W-1:0];
  assign p2_out = (fetch_ext || (is_data && wide)) ? addr_now[ADDR_W-1:DATA_W] : p2_hold;

  assign cap = (fetch_ext && (hph == PSEN_END)) || (is_rd && (ph == STB_END));
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= din;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wide,
  input  logic              int_code_en,
  input  logic [HI_W-1:0]   p2_hold,
  input  logic [DATA_W-1:0] p0_in,
  output logic              cyc_last,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [HI_W-1:0]   p2_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  xkind_t            cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_wide;
  logic              cur_int_en;

  ph_t  ph, hph;
  logic half;
  logic [1:0][ADDR_W-1:0] haddr;
  logic [1:0]             ext;
  logic                   sel_half;
  logic                   ext_now;
  logic [ADDR_W-1:0]      addr_now;
  logic                   cap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind   <= XK_IDLE;
      cur_addr   <= '0;
      cur_wdata  <= '0;
      cur_wide   <= 1'b0;
      cur_int_en <= 1'b0;
    end else if (cyc_last) begin
      cur_kind   <= xkind_t'(req_kind);
      cur_addr   <= req_addr;
      cur_wdata  <= req_wdata;
      cur_wide   <= req_wide;
      cur_int_en <= int_code_en;
    end
  end

  xbus_phase u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .ph   (ph),
    .hph  (hph),
    .half (half),
    .last (cyc_last)
  );

  xbus_code_dec #(.ADDR_W(ADDR_W), .INT_LAST(INT_LAST)) u_dec (
    .base  (cur_addr),
    .int_en(cur_int_en),
    .haddr (haddr),
    .ext   (ext)
  );

  assign sel_half = half && (cur_kind == XK_FETCH);
  assign ext_now  = ext[sel_half];
  assign addr_now = haddr[sel_half];

  xbus_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .kind    (cur_kind),
    .ph      (ph),
    .hph     (hph),
    .half    (half),
    .ext_now (ext_now),
    .addr_now(addr_now),
    .wdata   (cur_wdata),
    .wide    (cur_wide),
    .p2_hold (p2_hold),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .p0_out  (p0_out),
    .p0_oe   (p0_oe),
    .p2_out  (p2_out),
    .cap     (cap_evt)
  );

  xbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_evt),
    .din   (p0_in),
    .rdata (rdata),
    .rvalid(rvalid)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_last,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              p0_oe,
  input logic [DATA_W-1:0] p0_out,
  input logic [DATA_W-1:0] p0_in,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              cap_evt
);
  ph_t gap, ale_hi, psen_lo, stb_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= PH_LAST;
      ale_hi  <= PH_ZERO;
      psen_lo <= PH_ZERO;
      stb_lo  <= PH_ZERO;
    end else begin
      gap     <= cyc_last ? PH_ZERO : gap + ph_t'(1);
      ale_hi  <= ale ? ale_hi + ph_t'(1) : PH_ZERO;
      psen_lo <= !psen_n ? psen_lo + ph_t'(1) : PH_ZERO;
      stb_lo  <= (!rd_n || !wr_n) ? stb_lo + ph_t'(1) : PH_ZERO;
    end
  end

  // R2
  cyc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |-> (gap == PH_LAST));

  // R3
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ale_hi == ALE_CLKS));

  // R4
  psen_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psen_n) |-> (psen_lo == PSEN_CLKS));

  // R4
  psen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));

  // R6
  p0_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !p0_oe);

  // R7
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> (stb_lo == STB_CLKS));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out)));

  // R10
  cap_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (($past(p0_in) == rdata) && ($rose(psen_n) || $rose(rd_n))));

  // R10
  cap_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> rvalid);
endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cyc_last(cyc_last),
  .ale     (ale),
  .psen_n  (psen_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .p0_oe   (p0_oe),
  .p0_out  (p0_out),
  .p0_in   (p0_in),
  .rdata   (rdata),
  .rvalid  (rvalid),
  .cap_evt (cap_evt)
);

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_wide, int_code_en;
  logic [7:0]  p2_hold, p0_in;
  logic        cyc_last, ale, psen_n, rd_n, wr_n, p0_oe, rvalid;
  logic [7:0]  p0_out, p2_out, rdata;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wide(req_wide), .int_code_en(int_code_en),
    .p2_hold(p2_hold), .p0_in(p0_in), .cyc_last(cyc_last), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0] kind; logic [15:0] addr; logic [7:0] wdata;
    logic wide; logic ie; logic [7:0] p2;
  } cyc_t;
  typedef struct { bit is_wr; logic [15:0] addr; logic [7:0] data; } sb_t;

  cyc_t cyc_q[$];
  sb_t  sb_q[$];

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic bit is_ext(logic [15:0] a, logic ie);
    return !ie || (a > 16'h0FFF);
  endfunction

  // external memory model: address latched when ALE falls
  logic [15:0] la = 16'h0;
  assign p0_in = (!psen_n || !rd_n) ? mem_byte(la) : 8'hEE;

  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd,
                       input logic wide, input logic ie, input logic [7:0] p2);
    cyc_t c;
    logic [15:0] ea;
    req_kind = k; req_addr = a; req_wdata = wd; req_wide = wide;
    int_code_en = ie; p2_hold = p2;
    c.kind = k; c.addr = a; c.wdata = wd; c.wide = wide; c.ie = ie; c.p2 = p2;
    cyc_q.push_back(c);
    ea = wide ? a : {p2, a[7:0]};
    if (k == 2'd1) begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] ha;
        ha = a + 16'(h);
        if (is_ext(ha, ie)) sb_q.push_back('{1'b0, ha, mem_byte(ha)});
      end
    end else if (k == 2'd2) sb_q.push_back('{1'b0, ea, mem_byte(ea)});
    else if (k == 2'd3) sb_q.push_back('{1'b1, ea, wd});
    do @(negedge clk); while (!cyc_last);
  endtask

  // monitor state
  int idx, ale_clks, ale_pulses, psen_clks, psen_first, rd_clks, wr_clks, stb_first;
  bit prev_last, prev_ale;
  logic [7:0] p2a, p2b, p0a, p0b, d11;
  bit oea, oeb, oe11, wr11;

  task automatic eval_cycle(input cyc_t c);
    bit e0, e1, fe, dt;
    logic [15:0] h1;
    logic [7:0] x2a, x2b;
    h1 = c.addr + 16'd1;
    e0 = is_ext(c.addr, c.ie);
    e1 = is_ext(h1, c.ie);
    fe = (c.kind == 2'd1);
    dt = c.kind[1];
    chk(ale_clks == (dt ? 2 : 4), "R3", "ale high clocks", ale_clks, dt ? 2 : 4);
    chk(ale_pulses == (dt ? 1 : 2), "R3", "ale pulses", ale_pulses, dt ? 1 : 2);
    chk(psen_clks == (fe ? 3 * (int'(e0) + int'(e1)) : 0), "R4 R5", "psen low clocks",
        psen_clks, fe ? 3 * (int'(e0) + int'(e1)) : 0);
    if (fe && e0) chk(psen_first == 3, "R4", "psen first clock", psen_first, 3);
    chk(rd_clks == (c.kind == 2'd2 ? 6 : 0), "R7", "rd low clocks", rd_clks, c.kind == 2'd2 ? 6 : 0);
    chk(wr_clks == (c.kind == 2'd3 ? 6 : 0), "R7", "wr low clocks", wr_clks, c.kind == 2'd3 ? 6 : 0);
    if (dt) chk(stb_first == 5, "R7", "strobe first clock", stb_first, 5);
    x2a = fe ? (e0 ? c.addr[15:8] : c.p2) : (dt && c.wide) ? c.addr[15:8] : c.p2;
    x2b = fe ? (e1 ? h1[15:8] : c.p2) : (dt && c.wide) ? c.addr[15:8] : c.p2;
    chk(p2a == x2a, "R9", "p2 first half", p2a, x2a);
    chk(p2b == x2b, "R9", "p2 second half", p2b, x2b);
    chk(oea == (fe ? e0 : dt), "R6 R5", "p0 drive clock 1", oea, fe ? e0 : dt);
    if (oea && (fe ? e0 : dt)) chk(p0a == c.addr[7:0], "R6", "p0 address clock 1", p0a, c.addr[7:0]);
    chk(oeb == (fe ? e1 : (c.kind == 2'd3)), "R6 R8", "p0 drive clock 7", oeb, fe ? e1 : (c.kind == 2'd3));
    if (fe && e1 && oeb) chk(p0b == h1[7:0], "R6", "p0 address clock 7", p0b, h1[7:0]);
    if (c.kind == 2'd3) begin
      chk(p0b == c.wdata, "R8", "write data clock 7", p0b, c.wdata);
      chk(wr11 && oe11 && d11 == c.wdata, "R8", "write data hold", {wr11, oe11, d11}, {2'b11, c.wdata});
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_last = 1'b1; prev_ale = 1'b0;
      idx = 0; ale_clks = 0; ale_pulses = 0; psen_clks = 0; rd_clks = 0; wr_clks = 0;
      psen_first = -1; stb_first = -1;
    end else begin
      idx = prev_last ? 0 : idx + 1;
      if (prev_ale && !ale) la = {p2_out, p0_out};
      if (ale) ale_clks++;
      if (ale && !prev_ale) ale_pulses++;
      if (!psen_n) begin if (psen_clks == 0) psen_first = idx; psen_clks++; end
      if (!rd_n) begin if (rd_clks == 0) stb_first = idx; rd_clks++; end
      if (!wr_n) begin if (wr_clks == 0) stb_first = idx; wr_clks++; end
      if (idx == 1) begin p2a = p2_out; oea = p0_oe; p0a = p0_out; end
      if (idx == 7) begin p2b = p2_out; oeb = p0_oe; p0b = p0_out; end
      if (idx == 11) begin oe11 = p0_oe; d11 = p0_out; wr11 = wr_n; end
      if (idx == 10 && !wr_n) begin
        if (sb_q.size() == 0) chk(0, "R8", "unexpected write", la, 0);
        else begin
          sb_t s;
          s = sb_q.pop_front();
          chk(s.is_wr && la == s.addr, "R8 R9", "write address", la, s.addr);
          chk(p0_out == s.data, "R8", "write data", p0_out, s.data);
        end
      end
      if (rvalid) begin
        if (sb_q.size() == 0) chk(0, "R10", "unexpected rvalid", rdata, 0);
        else begin
          sb_t s;
          s = sb_q.pop_front();
          chk(!s.is_wr && rdata == s.data, "R10", "returned byte", rdata, s.data);
          chk(la == s.addr, "R10 R5", "bus address", la, s.addr);
        end
      end
      if (cyc_last) begin
        chk(idx == 11, "R2", "cycle length", idx + 1, 12);
        if (cyc_q.size() != 0) eval_cycle(cyc_q.pop_front());
        ale_clks = 0; ale_pulses = 0; psen_clks = 0; rd_clks = 0; wr_clks = 0;
        psen_first = -1; stb_first = -1;
      end
      prev_last = cyc_last; prev_ale = ale;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    rst_n = 1'b0;
    req_kind = 2'd0; req_addr = 16'h0; req_wdata = 8'h0;
    req_wide = 1'b0; int_code_en = 1'b0; p2_hold = 8'h00;
    repeat (3) @(negedge clk);
    chk(ale == 1'b0, "R1", "ale in reset", ale, 0);
    chk(psen_n && rd_n && wr_n, "R1", "strobes in reset", {psen_n, rd_n, wr_n}, 3'b111);
    chk(!p0_oe && !rvalid, "R1", "p0_oe rvalid in reset", {p0_oe, rvalid}, 0);
    chk(cyc_last == 1'b1, "R1", "cyc_last in reset", cyc_last, 1);
    #2 rst_n = 1'b1;
    issue(2'd0, 16'h1234, 8'h00, 1'b0, 1'b1, 8'h4D);   // idle
    issue(2'd1, 16'h0010, 8'h00, 1'b0, 1'b0, 8'h11);   // all external
    issue(2'd1, 16'h0100, 8'h00, 1'b0, 1'b1, 8'h22);   // both internal
    issue(2'd1, 16'h0FFF, 8'h00, 1'b0, 1'b1, 8'h33);   // boundary: second byte external
    issue(2'd1, 16'h2345, 8'h00, 1'b0, 1'b1, 8'h44);
    issue(2'd2, 16'h8123, 8'h00, 1'b1, 1'b1, 8'h55);   // wide read
    issue(2'd2, 16'h0045, 8'h00, 1'b0, 1'b1, 8'h7E);   // narrow read
    issue(2'd3, 16'h4321, 8'hA7, 1'b1, 1'b1, 8'h66);   // wide write
    issue(2'd3, 16'h0088, 8'h5C, 1'b0, 1'b1, 8'h19);   // narrow write
    issue(2'd1, 16'hFFFF, 8'h00, 1'b0, 1'b0, 8'h77);   // address wrap
    issue(2'd3, 16'h1111, 8'hC3, 1'b1, 1'b0, 8'h01);
    issue(2'd1, 16'h3000, 8'h00, 1'b0, 1'b0, 8'h02);   // fetch right after write
    s = 16'hACE1;
    for (int i = 0; i < 30; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      issue(s[1:0], (s ^ 16'h5A5A) & (s[7] ? 16'h1FFF : 16'hFFFF), s[11:4], s[6], s[9], s[15:8]);
    end
    issue(2'd0, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00);
    issue(2'd0, 16'h0, 8'h0, 1'b0, 1'b0, 8'h00);
    chk(sb_q.size() == 0, "R10", "scoreboard drained", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule